// File: doc/BRIEF.md
# Command Stream Register-Write Engine

This block interprets a buffer of 32-bit command words and turns it into register write transactions. Software fills a buffer with variable-length packets, tells the engine how many words the buffer holds and pulses `start`. The engine pulls words through a valid/ready input stream. For each packet it decodes the opcode in the top byte of the first word and applies bounds checks to the header before any payload word is consumed. It then issues the resulting writes on a valid/ready register write port.

Writes are made relative to a current base address. A base-change packet selects that base by searching a small configuration table of (24-bit key, 32-bit base) pairs. Four packet types produce writes: a run of values to consecutive registers, a list of (offset, value) pairs, and two forms of streaming into a table-load data port. The narrow form sends each payload word to the low port. The wide form sends word pairs to the low and high ports. Any other opcode, a malformed length or a missing base stops processing, and the error and its code are held until the next start.

Top module: `cmdstream_regwr`

## Requirements
- R1: Opcode 3 (range write): `count` sits in word 0 bits [15:0] and a 24-bit offset in word 1 bits [23:0]. The next `count` words are written in order to base+offset, base+offset+4, base+offset+8 and so on.
- R2: Opcode 4 (pair write): `count` sits in word 0 bits [15:0] and is followed by `count` pairs of words. Each pair writes its second word to base plus the full 32-bit first word.
- R3: Opcode 8 (base change): bits [23:0] are compared with the key of every enabled table entry. The lowest-index match becomes the current base. A packet that matches no entry stops the engine with error code 5.
- R4: Opcode 10 (narrow port load): word 0 bits [15:0] hold the byte length minus one, word 1 is ignored, and word 2 bits [23:0] hold the port offset (bits [31:24] are ignored). The engine writes floor((len+1)/4) payload words, each to base+port offset+LO_OFS (default 0x0C).
- R5: Opcode 11 (wide port load): the header is laid out as for opcode 10. There are floor((len+1)/8) pairs of payload words. The first word of each pair goes to base+port offset+LO_OFS and the second to base+port offset+HI_OFS (default 0x10).
- R6: Any opcode other than 3, 4, 8, 10 or 11 stops the engine with error code 1. No write is issued for that packet.
- R7: A range or pair packet with count 0 stops the engine with error code 2, and so does a port-load packet whose payload word count is 0.
- R8: A packet whose header plus payload is longer than the words left in the buffer stops the engine with error code 3, and none of its writes is issued. Error checks have the priority code 1, then 2, then 3, then 4.
- R9: A write-producing packet (opcode 3, 4, 10 or 11) that arrives while no base has been selected since `start` stops the engine with error code 4.
- R10: When every word of the buffer has been consumed without error and the last write has left the port, `done` is high for exactly one cycle, with `wr_valid` low. A start with `word_total` = 0 gives a `done` pulse and no writes.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged.
- R12: `err` and `err_code` hold their values until the next `start`, which clears them and forgets the selected base. While not busy the engine keeps `in_ready` low, and after an error it consumes no further words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a buffer (ignored while busy) |
| word_total | input | CNT_W | Number of words in the buffer |
| in_valid | input | 1 | Command word valid |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Engine accepts the command word |
| cfg_we | input | 1 | Write one base table entry |
| cfg_idx | input | IDX_W | Table entry index |
| cfg_key | input | 24 | Match key for the entry |
| cfg_base | input | 32 | Write base for the entry |
| cfg_en | input | 1 | Entry enable |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Register write accepted |
| wr_addr | output | 32 | Register write address |
| wr_data | output | 32 | Register write data |
| busy | output | 1 | Engine is processing a buffer |
| done | output | 1 | One-cycle pulse on clean completion |
| err | output | 1 | Processing stopped on an error |
| err_code | output | 3 | 0 none, 1 opcode, 2 zero count, 3 overrun, 4 no base, 5 no match |

## Verification
Two things can happen in the same clock edge: a payload word is taken in, and the previous write leaves the output register. The engine may refill the register only when that hand-off completes in the same edge. Random gaps on `in_valid` and random drops of `wr_ready` create every mix of stall and simultaneous hand-off. The captured write sequence is compared with the one predicted by a model of the buffer, and addresses and data must stay unchanged across every stalled cycle. The last write and the `done` pulse are a second such meeting point. The bench checks that `done` is never seen while a write is still pending.

// File: rtl/cmdstream_pkg.sv
package cmdstream_pkg;

  localparam logic [7:0] OP_RANGE  = 8'd3;
  localparam logic [7:0] OP_PAIRS  = 8'd4;
  localparam logic [7:0] OP_REBASE = 8'd8;
  localparam logic [7:0] OP_PORT32 = 8'd10;
  localparam logic [7:0] OP_PORT64 = 8'd11;

  typedef enum logic [2:0] {
    FAULT_NONE    = 3'd0,
    FAULT_OPCODE  = 3'd1,
    FAULT_ZERO    = 3'd2,
    FAULT_OVERRUN = 3'd3,
    FAULT_NOBASE  = 3'd4,
    FAULT_NOMATCH = 3'd5
  } fault_e;

  typedef enum logic [3:0] {
    PS_IDLE,
    PS_HEAD,
    PS_RANGE_OFS,
    PS_RANGE_DAT,
    PS_PAIR_OFS,
    PS_PAIR_VAL,
    PS_PORT_BUF,
    PS_PORT_SEL,
    PS_PORT_DAT,
    PS_FINISH
  } pstate_e;

endpackage

// File: rtl/csw_base_table.sv
module csw_base_table #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3,
  parameter int KEY_W   = 24,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [KEY_W-1:0]  cfg_key,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              cfg_en,
  input  logic [KEY_W-1:0]  q_key,
  output logic              q_hit,
  output logic [ADDR_W-1:0] q_base
);

  logic [KEY_W-1:0]  key_q  [ENTRIES];
  logic [ADDR_W-1:0] base_q [ENTRIES];
  logic [ENTRIES-1:0] en_q;
  logic [ENTRIES-1:0] hit_v;

  // enables carry reset; key and base storage needs none
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (cfg_we) begin
      en_q[cfg_idx] <= cfg_en;
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      key_q[cfg_idx]  <= cfg_key;
      base_q[cfg_idx] <= cfg_base;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_v[g] = en_q[g] && (key_q[g] == q_key);
  end

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    q_hit  = 1'b0;
    q_base = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        q_hit  = 1'b1;
        q_base = base_q[i];
      end
    end
  end

endmodule

// File: rtl/csw_wr_stage.sv
module csw_wr_stage #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              free
);

  assign free = !wr_valid || wr_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
    end else if (load) begin
      wr_valid <= 1'b1;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr <= '0;
      wr_data <= '0;
    end else if (load) begin
      wr_addr <= ld_addr;
      wr_data <= ld_data;
    end
  end

endmodule

// File: rtl/csw_parser.sv
module csw_parser
  import cmdstream_pkg::*;
#(
  parameter int          CNT_W  = 20,
  parameter logic [31:0] LO_OFS = 32'h0000_000C,
  parameter logic [31:0] HI_OFS = 32'h0000_0010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] word_total,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  output logic             in_ready,
  input  logic             out_free,
  output logic             load,
  output logic [31:0]      ld_addr,
  output logic [31:0]      ld_data,
  output logic [23:0]      q_key,
  input  logic             q_hit,
  input  logic [31:0]      q_base,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [2:0]       err_code
);

  localparam int PCW = 17;
  localparam int NW  = CNT_W + 19;

  pstate_e          st;
  fault_e           fault_q, head_fault;
  logic [CNT_W-1:0] remain;
  logic [PCW-1:0]   cnt;
  logic [31:0]      base_q, addr_q, hi_q;
  logic             base_vld, wide, hi_turn;

  logic [7:0]     op;
  logic [15:0]    fld;
  logic [16:0]    len1;
  logic [PCW-1:0] port_n;
  logic [NW-1:0]  need;
  logic           is_wr, known, pay_zero, last, accept, dat_state;

  // header decode of the word on the input
  always_comb begin
    op     = in_data[31:24];
    fld    = in_data[15:0];
    len1   = {1'b0, fld} + 17'd1;
    port_n = (op == OP_PORT64) ? PCW'((len1 >> 3) << 1) : PCW'(len1 >> 2);
    is_wr  = (op == OP_RANGE) || (op == OP_PAIRS) ||
             (op == OP_PORT32) || (op == OP_PORT64);
    known  = is_wr || (op == OP_REBASE);
    case (op)
      OP_RANGE:  begin need = NW'(fld) + NW'(2);          pay_zero = (fld == 16'd0); end
      OP_PAIRS:  begin need = (NW'(fld) << 1) + NW'(1);   pay_zero = (fld == 16'd0); end
      OP_PORT32,
      OP_PORT64: begin need = NW'(port_n) + NW'(3);       pay_zero = (port_n == '0); end
      default:   begin need = NW'(1);                     pay_zero = 1'b0;           end
    endcase
    if (!known)                    head_fault = FAULT_OPCODE;
    else if (pay_zero)             head_fault = FAULT_ZERO;
    else if (need > NW'(remain))   head_fault = FAULT_OVERRUN;
    else if (is_wr && !base_vld)   head_fault = FAULT_NOBASE;
    else                           head_fault = FAULT_NONE;
  end

  assign dat_state = (st == PS_RANGE_DAT) || (st == PS_PAIR_VAL) || (st == PS_PORT_DAT);

  always_comb begin
    case (st)
      PS_HEAD, PS_RANGE_OFS, PS_PAIR_OFS, PS_PORT_BUF, PS_PORT_SEL: in_ready = 1'b1;
      PS_RANGE_DAT, PS_PAIR_VAL, PS_PORT_DAT:                        in_ready = out_free;
      default:                                                       in_ready = 1'b0;
    endcase
  end

  assign accept   = in_valid && in_ready;
  assign last     = (remain == CNT_W'(1));
  assign load     = accept && dat_state;
  assign ld_addr  = hi_turn ? hi_q : addr_q;
  assign ld_data  = in_data;
  assign q_key    = in_data[23:0];
  assign busy     = (st != PS_IDLE);
  assign err_code = fault_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= PS_IDLE;
      fault_q  <= FAULT_NONE;
      err      <= 1'b0;
      done     <= 1'b0;
      remain   <= '0;
      cnt      <= '0;
      base_q   <= '0;
      addr_q   <= '0;
      hi_q     <= '0;
      base_vld <= 1'b0;
      wide     <= 1'b0;
      hi_turn  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) remain <= remain - CNT_W'(1);
      case (st)
        PS_IDLE: begin
          if (start) begin
            remain   <= word_total;
            base_vld <= 1'b0;
            err      <= 1'b0;
            fault_q  <= FAULT_NONE;
            st       <= (word_total == '0) ? PS_FINISH : PS_HEAD;
          end
        end
        PS_HEAD: begin
          if (accept) begin
            if (head_fault != FAULT_NONE) begin
              err     <= 1'b1;
              fault_q <= head_fault;
              st      <= PS_IDLE;
            end else begin
              case (op)
                OP_RANGE: begin cnt <= PCW'(fld); st <= PS_RANGE_OFS; end
                OP_PAIRS: begin cnt <= PCW'(fld); st <= PS_PAIR_OFS;  end
                OP_PORT32, OP_PORT64: begin
                  cnt  <= port_n;
                  wide <= (op == OP_PORT64);
                  st   <= PS_PORT_BUF;
                end
                default: begin
                  if (q_hit) begin
                    base_q   <= q_base;
                    base_vld <= 1'b1;
                    st       <= last ? PS_FINISH : PS_HEAD;
                  end else begin
                    err     <= 1'b1;
                    fault_q <= FAULT_NOMATCH;
                    st      <= PS_IDLE;
                  end
                end
              endcase
            end
          end
        end
        PS_RANGE_OFS: begin
          if (accept) begin
            addr_q <= base_q + {8'h00, in_data[23:0]};
            st     <= PS_RANGE_DAT;
          end
        end
        PS_RANGE_DAT: begin
          if (accept) begin
            addr_q <= addr_q + 32'd4;
            cnt    <= cnt - PCW'(1);
            if (cnt == PCW'(1)) st <= last ? PS_FINISH : PS_HEAD;
          end
        end
        PS_PAIR_OFS: begin
          if (accept) begin
            addr_q <= base_q + in_data;
            st     <= PS_PAIR_VAL;
          end
        end
        PS_PAIR_VAL: begin
          if (accept) begin
            cnt <= cnt - PCW'(1);
            if (cnt == PCW'(1)) st <= last ? PS_FINISH : PS_HEAD;
            else                st <= PS_PAIR_OFS;
          end
        end
        PS_PORT_BUF: begin
          if (accept) st <= PS_PORT_SEL;
        end
        PS_PORT_SEL: begin
          if (accept) begin
            addr_q  <= base_q + {8'h00, in_data[23:0]} + LO_OFS;
            hi_q    <= base_q + {8'h00, in_data[23:0]} + HI_OFS;
            hi_turn <= 1'b0;
            st      <= PS_PORT_DAT;
          end
        end
        PS_PORT_DAT: begin
          if (accept) begin
            cnt     <= cnt - PCW'(1);
            hi_turn <= wide && !hi_turn;
            if (cnt == PCW'(1)) begin
              hi_turn <= 1'b0;
              st      <= last ? PS_FINISH : PS_HEAD;
            end
          end
        end
        PS_FINISH: begin
          if (out_free) begin
            done <= 1'b1;
            st   <= PS_IDLE;
          end
        end
        default: st <= PS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmdstream_regwr.sv
module cmdstream_regwr #(
  parameter int          ENTRIES = 8,
  parameter int          CNT_W   = 20,
  parameter logic [31:0] LO_OFS  = 32'h0000_000C,
  parameter logic [31:0] HI_OFS  = 32'h0000_0010,
  localparam int         IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] word_total,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  output logic             in_ready,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [23:0]      cfg_key,
  input  logic [31:0]      cfg_base,
  input  logic             cfg_en,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [31:0]      wr_addr,
  output logic [31:0]      wr_data,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [2:0]       err_code
);

  logic        out_free, load, q_hit;
  logic [31:0] ld_addr, ld_data, q_base;
  logic [23:0] q_key;

  csw_base_table #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .KEY_W   (24),
    .ADDR_W  (32)
  ) u_table (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_key  (cfg_key),
    .cfg_base (cfg_base),
    .cfg_en   (cfg_en),
    .q_key    (q_key),
    .q_hit    (q_hit),
    .q_base   (q_base)
  );

  csw_parser #(
    .CNT_W  (CNT_W),
    .LO_OFS (LO_OFS),
    .HI_OFS (HI_OFS)
  ) u_parser (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .word_total (word_total),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .out_free   (out_free),
    .load       (load),
    .ld_addr    (ld_addr),
    .ld_data    (ld_data),
    .q_key      (q_key),
    .q_hit      (q_hit),
    .q_base     (q_base),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .err_code   (err_code)
  );

  csw_wr_stage #(
    .ADDR_W (32),
    .DATA_W (32)
  ) u_wr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .wr_ready (wr_ready),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .free     (out_free)
  );

endmodule

// File: rtl/cmdstream_regwr_chk.sv
module cmdstream_regwr_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        in_ready,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [31:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [2:0]  err_code
);

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R11

  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_valid); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    done |-> !err); // R10

  AST_ERR_LATCH: assert property (@(posedge clk) disable iff (rst)
    err && !start |=> err && $stable(err_code)); // R12

  AST_ERR_CODE_KNOWN: assert property (@(posedge clk) disable iff (rst)
    err |-> (err_code != 3'd0) && (err_code <= 3'd5)); // R6

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy); // R8

  AST_IDLE_NO_INTAKE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !in_ready); // R12

endmodule

bind cmdstream_regwr cmdstream_regwr_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .in_ready (in_ready),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .err_code (err_code)
);

// File: tb/cmdstream_regwr_tb.sv
module cmdstream_regwr_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 8;
  localparam int CNT_W      = 20;
  localparam int MAXW       = 256;
  localparam int WD_LIMIT   = 150000;
  localparam logic [31:0] LO = 32'h0000_000C;
  localparam logic [31:0] HI = 32'h0000_0010;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [CNT_W-1:0] word_total = '0;
  logic             in_valid = 1'b0;
  logic [31:0]      in_data = '0;
  logic             in_ready;
  logic             cfg_we = 1'b0;
  logic [2:0]       cfg_idx = '0;
  logic [23:0]      cfg_key = '0;
  logic [31:0]      cfg_base = '0;
  logic             cfg_en = 1'b0;
  logic             wr_valid;
  logic             wr_ready = 1'b0;
  logic [31:0]      wr_addr, wr_data;
  logic             busy, done, err;
  logic [2:0]       err_code;

  cmdstream_regwr #(.ENTRIES(ENTRIES), .CNT_W(CNT_W), .LO_OFS(LO), .HI_OFS(HI)) u_dut (
    .clk(clk), .rst(rst), .start(start), .word_total(word_total),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_key(cfg_key), .cfg_base(cfg_base), .cfg_en(cfg_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .err(err), .err_code(err_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [23:0] t_key  [ENTRIES];
  logic [31:0] t_base [ENTRIES];
  bit          t_en   [ENTRIES];
  logic [31:0] bufm   [MAXW];
  int          n_words;
  logic [31:0] e_addr[$], e_data[$], g_addr[$], g_data[$];
  int          e_code;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic add(logic [31:0] w);
    if (n_words < MAXW) begin
      bufm[n_words] = w;
      n_words++;
    end
  endtask

  task automatic pkt_range(logic [23:0] ofs, int cnt);
    add({8'd3, 8'h00, 16'(cnt)});
    add({8'h00, ofs});
    for (int i = 0; i < cnt; i++) add($urandom);
  endtask

  task automatic pkt_pairs(int cnt);
    add({8'd4, 8'h00, 16'(cnt)});
    for (int i = 0; i < cnt; i++) begin
      add($urandom % 4096 & 32'hFFFF_FFFC);
      add($urandom);
    end
  endtask

  task automatic pkt_port(bit wide, int len_m1);
    int nw;
    nw = wide ? ((len_m1 + 1) / 8) * 2 : (len_m1 + 1) / 4;
    add({wide ? 8'd11 : 8'd10, 8'h00, 16'(len_m1)});
    add($urandom);
    add({8'($urandom), 24'($urandom % 65536)});
    for (int i = 0; i < nw; i++) add($urandom);
  endtask

  task automatic pkt_rebase(logic [23:0] key);
    add({8'd8, key});
  endtask

  // reference interpretation of the buffer
  task automatic model();
    int p;
    logic [31:0] base;
    bit bok;
    p = 0; base = '0; bok = 1'b0;
    e_addr.delete(); e_data.delete(); e_code = 0;
    while (p < n_words && e_code == 0) begin
      logic [31:0] w;
      int op, c, rem, need, nw;
      bit wrop, zero, hit;
      w = bufm[p]; op = int'(w[31:24]); c = int'(w[15:0]); rem = n_words - p;
      need = 1; nw = 0; wrop = 0; zero = 0;
      case (op)
        3:       begin nw = c; need = 2 + c; wrop = 1; zero = (c == 0); end
        4:       begin nw = c; need = 1 + 2 * c; wrop = 1; zero = (c == 0); end
        10:      begin nw = (c + 1) / 4; need = 3 + nw; wrop = 1; zero = (nw == 0); end
        11:      begin nw = ((c + 1) / 8) * 2; need = 3 + nw; wrop = 1; zero = (nw == 0); end
        8:       need = 1;
        default: e_code = 1;
      endcase
      if (e_code == 0) begin
        if (zero)               e_code = 2;
        else if (need > rem)    e_code = 3;
        else if (wrop && !bok)  e_code = 4;
      end
      if (e_code == 0) begin
        case (op)
          8: begin
            hit = 0;
            for (int i = ENTRIES - 1; i >= 0; i--)
              if (t_en[i] && t_key[i] == w[23:0]) begin hit = 1; base = t_base[i]; end
            if (hit) bok = 1; else e_code = 5;
          end
          3: for (int i = 0; i < nw; i++) begin
               e_addr.push_back(base + {8'h00, bufm[p+1][23:0]} + 32'(4 * i));
               e_data.push_back(bufm[p+2+i]);
             end
          4: for (int i = 0; i < nw; i++) begin
               e_addr.push_back(base + bufm[p+1+2*i]);
               e_data.push_back(bufm[p+2+2*i]);
             end
          default: for (int i = 0; i < nw; i++) begin
               e_addr.push_back(base + {8'h00, bufm[p+2][23:0]} + ((op == 11 && i % 2 == 1) ? HI : LO));
               e_data.push_back(bufm[p+3+i]);
             end
        endcase
      end
      p += need;
    end
  endtask

  task automatic cfg_entry(int idx, logic [23:0] key, logic [31:0] base, bit en);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_key = key; cfg_base = base; cfg_en = en;
    @(negedge clk);
    cfg_we = 0;
    t_key[idx] = key; t_base[idx] = base; t_en[idx] = en;
  endtask

  task automatic run(string req, int gap);
    bit got_done, prev_stall, all_ok;
    int idx;
    logic [31:0] h_addr, h_data;
    model();
    g_addr.delete(); g_data.delete();
    @(negedge clk);
    word_total = CNT_W'(n_words); start = 1;
    @(negedge clk);
    start = 0;
    chk(err == 0, "R12", "err cleared by start", err, 0);
    idx = 0; got_done = 0; prev_stall = 0; h_addr = '0; h_data = '0;
    while (cyc < WD_LIMIT) begin
      if (done) begin got_done = 1; break; end
      if (!busy) break;
      in_valid = (idx < n_words) && (($urandom % 100) >= gap);
      in_data  = bufm[idx % MAXW];
      wr_ready = ($urandom % 100) >= gap;
      #1;
      if (prev_stall)
        chk(wr_valid && wr_addr == h_addr && wr_data == h_data, "R11", "held write", wr_addr, h_addr);
      if (in_valid && in_ready) idx++;
      if (wr_valid && wr_ready) begin g_addr.push_back(wr_addr); g_data.push_back(wr_data); end
      prev_stall = wr_valid && !wr_ready;
      h_addr = wr_addr; h_data = wr_data;
      @(negedge clk);
    end
    in_valid = 0;
    wr_ready = 1;
    if (got_done) begin
      @(negedge clk);
      chk(done == 0, "R10", "done one cycle", done, 0);
    end
    for (int k = 0; k < 3; k++) begin
      #1;
      if (wr_valid && wr_ready) begin g_addr.push_back(wr_addr); g_data.push_back(wr_data); end
      @(negedge clk);
    end
    chk(got_done == (e_code == 0), req, "done seen", got_done, e_code == 0);
    chk(err == (e_code != 0), req, "err flag", err, e_code != 0);
    chk(int'(err_code) == e_code, req, "err_code", err_code, e_code);
    chk(g_addr.size() == e_addr.size(), req, "write count", g_addr.size(), e_addr.size());
    all_ok = 1;
    for (int i = 0; i < g_addr.size() && i < e_addr.size(); i++)
      if (all_ok && (g_addr[i] != e_addr[i] || g_data[i] != e_data[i])) begin
        all_ok = 0;
        chk(0, req, $sformatf("write %0d addr", i), g_addr[i], e_addr[i]);
      end
    if (all_ok) chk(1, req, "writes", 0, 0);
  endtask

  // watchdog
  initial begin
    wait (cyc >= WD_LIMIT);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WD_LIMIT);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < ENTRIES; i++) begin t_en[i] = 0; t_key[i] = '0; t_base[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    in_valid = 1;
    #1;
    chk(!in_ready && !wr_valid && !busy && !done && !err, "R12", "reset state idle",
        {in_ready, wr_valid, busy, done, err}, 0);
    in_valid = 0;

    for (int i = 0; i < ENTRIES - 1; i++)
      cfg_entry(i, 24'h10_0000 + 24'(i * 24'h111), 32'h4000_0000 + (32'(i) << 16), 1);

    // R1 directed range write
    n_words = 0; pkt_rebase(24'h10_0111); pkt_range(24'h000100, 3); run("R1", 0);
    // R2 directed pair write
    n_words = 0; pkt_rebase(24'h10_0222); pkt_pairs(3); run("R2", 0);
    // R4 narrow port load, ignored buffer word
    n_words = 0; pkt_rebase(24'h10_0000); pkt_port(0, 15); run("R4", 0);
    // R5 wide port load, two pairs then one pair
    n_words = 0; pkt_rebase(24'h10_0333); pkt_port(1, 15); pkt_port(1, 7); run("R5", 20);
    // R6 unsupported opcodes after a good packet
    n_words = 0; pkt_rebase(24'h10_0111); pkt_range(24'h20, 2); add(32'h0500_0004); add(0); run("R6", 0);
    n_words = 0; add(32'h0900_0000); run("R6", 0);
    // R7 zero counts
    n_words = 0; pkt_rebase(24'h10_0111); pkt_range(24'h40, 0); run("R7", 0);
    n_words = 0; pkt_rebase(24'h10_0111); pkt_port(0, 2); run("R7", 0);
    // R8 overrun: pair count 3 with only two pairs present
    n_words = 0; pkt_rebase(24'h10_0111); add({8'd4, 8'h00, 16'd3}); add(4); add(1); add(8); add(2); run("R8", 0);
    // R9 no base selected since start
    n_words = 0; pkt_range(24'h10, 1); run("R9", 0);
    // R3 key with no entry, then priority between equal keys
    n_words = 0; pkt_rebase(24'hABCDEF); run("R3", 0);
    cfg_entry(5, 24'h10_0222, 32'h7700_0000, 1);
    n_words = 0; pkt_rebase(24'h10_0222); pkt_range(24'h8, 2); run("R3", 0);
    cfg_entry(2, 24'h10_0222, 32'h4002_0000, 0);
    n_words = 0; pkt_rebase(24'h10_0222); pkt_range(24'h8, 2); run("R3", 0);
    // R10 empty buffer
    n_words = 0; run("R10", 0);
    // R12 error persists while idle
    n_words = 0; add(32'h0600_0000); run("R12", 0);
    repeat (5) @(negedge clk);
    chk(err && err_code == 3'd1, "R12", "error held", err_code, 1);

    // random mixes with back-pressure (R1 R2 R4 R5 R11)
    for (int r = 0; r < 40; r++) begin
      int k;
      n_words = 0;
      pkt_rebase(24'h10_0000 + 24'(($urandom % 5) * 24'h111));
      k = 3 + $urandom % 5;
      for (int j = 0; j < k; j++) begin
        case ($urandom % 5)
          0: pkt_range(24'($urandom % 4096) & 24'hFFFFFC, 1 + $urandom % 4);
          1: pkt_pairs(1 + $urandom % 3);
          2: pkt_port(0, 3 + $urandom % 16);
          3: pkt_port(1, 7 + $urandom % 24);
          default: pkt_rebase(24'h10_0000 + 24'(($urandom % 7) * 24'h111));
        endcase
      end
      case ($urandom % 8)
        0: add(32'h0700_0000);
        1: pkt_range(24'h0, 0);
        2: add({8'd3, 8'h00, 16'd40});
        3: pkt_rebase(24'h00_0001);
        default: ;
      endcase
      run("R11", 10 + $urandom % 50);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule